// File: doc/BRIEF.md
# Indirect-Addressed Serial Control Port

A host reaches this block over four serial pins: an active-low select, a serial clock, a data input and a data output. Every access moves exactly one byte and is framed by the select line. No address travels with the data. The first bit of the byte, together with the fields last written into a configuration register, picks the destination. That destination is one of eight time-slot registers, four signalling control registers, or the configuration register itself. Certain configuration values turn the next access into a read of a per-channel status byte.

The serial pins are sampled by the block's own system clock. Serial clock edges are found by comparing each sample with the one before it. The select line idles high and the serial clock idles high. The host drops the select, then makes eight serial clock pulses, each a falling edge followed by a rising edge, and then raises the select. The register update takes effect only when the select rises. The block also times how long the select stays high between accesses. If that time is too short, it raises a sticky error flag.

Top module: `ind_serial_port`

## Requirements
- R1: After reset, the configuration register, all slot registers and all signalling registers read 0x00. The gap error flag is 0 and `sdoOe` is 0.
- R2: A write of exactly 8 bits whose first bit is 1 loads the byte into the configuration register. Bits are taken on falling serial clock edges, MSB first.
- R3: A write whose first bit is 0, with config bit 6 equal to 0, goes to a slot register. The channel is config[3:2]. Config[1:0] selects the bank: 01 is transmit (slot k = channel) and 10 is receive (slot k = 4 + channel). Slot k occupies `slotRegs[8k+7:8k]`. When config[1:0] is 00 or 11, the write is dropped.
- R4: A write whose first bit is 0, with config[6:4] = 101 and no read pending, loads the signalling register of channel config[3:2]. Channel c occupies `sigCtrl[8c+7:8c]`.
- R5: A write whose first bit is 0, with config bit 6 equal to 1 and config[6:4] not equal to 101, changes no register.
- R6: A configuration write with bits 6:4 = 101 makes the next access a read. That read shifts out the selected channel's status byte, MSB first, one bit per rising serial clock edge. It ignores the input data and changes no register. The access after it is a write again.
- R7: The status byte of channel c is `{statusIn[5c+4:5c], ch0Io[2:0]}`. Bits 2:0 always come from the channel-0 I/O pins, whichever channel is selected.
- R8: A write whose transfer has a number of falling serial clock edges other than 8 is discarded entirely.
- R9: `sdoOe` is 1 only while the select is low during a read access. During writes and idle it is 0, which means the output is released.
- R10: The select may stay high for fewer than MIN_GAP (3) rising serial clock edges before it falls again. When that happens, `gapErr` is set and stays set until reset. The first access after reset is not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial write data |
| statusIn | input | 20 | Upper five status bits per channel, 5 per channel |
| ch0Io | input | 3 | Channel-0 I/O pin levels (pin1 at bit 2) |
| sdo | output | 1 | Serial read data |
| sdoOe | output | 1 | Output enable for sdo (0 = high impedance) |
| cfgReg | output | 8 | Configuration register |
| slotRegs | output | 64 | Eight time-slot registers |
| sigCtrl | output | 32 | Four signalling control registers |
| gapErr | output | 1 | Sticky short-idle error |

## Verification
Each serial pin change is seen at the next rising system clock edge. Shifting and committing happen on that same edge, so a register written by an access shows its new value one system cycle after the sampled select rise. A read bit appears on `sdo` one system cycle after the sampled serial clock rise. The bench drives pins on falling system clock edges and holds each serial level for four system cycles. It samples `sdo`, `sdoOe` and the registers at least two cycles after the causing edge, so every result is settled before it is read.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int NUM_CH   = 4;
  localparam int REG_W    = 8;
  localparam int NUM_SLOT = 2 * NUM_CH;
  localparam int STAT_W   = 5;
  localparam int IO_W     = REG_W - STAT_W;

  typedef struct packed {
    logic shiftIn;     // falling serial edge inside an access
    logic shiftOut;    // rising serial edge inside a read
    logic loadTx;      // select fell: capture status byte
    logic commitWrite; // select rose after exactly 8 bits of a write
    logic endRead;     // select rose at the end of a read
  } ispStrobes_t;
endpackage

// File: rtl/isp_ctrl.sv
module isp_ctrl
  import isp_pkg::*;
#(
  parameter int MIN_GAP = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        rdPending,
  output ispStrobes_t strobes,
  output logic        sdoOe,
  output logic        gapErr
);
  localparam int CNT_W = 4;
  localparam int GAP_W = $clog2(MIN_GAP + 1);

  logic csQ, sclkQ;
  logic csFall, csRise, sclkFall, sclkRise, idleRise;
  logic [CNT_W-1:0] bitCnt;
  logic [GAP_W-1:0] gapCnt;
  logic readActive, sawAccess;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ   <= 1'b1;
      sclkQ <= 1'b1;
    end else begin
      csQ   <= csN;
      sclkQ <= sclk;
    end
  end

  always_comb begin
    csFall   = csQ & ~csN;
    csRise   = ~csQ & csN;
    sclkFall = sclkQ & ~sclk & ~csN & ~csQ;
    sclkRise = ~sclkQ & sclk & ~csN & ~csQ;
    idleRise = ~sclkQ & sclk & csN & csQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt     <= '0;
      readActive <= 1'b0;
    end else begin
      if (csFall) begin
        bitCnt     <= '0;
        readActive <= rdPending;
      end else begin
        if (sclkFall && bitCnt < CNT_W'(9)) bitCnt <= bitCnt + 1'b1;
        if (csRise) readActive <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt    <= '0;
      sawAccess <= 1'b0;
      gapErr    <= 1'b0;
    end else begin
      if (csRise) begin
        gapCnt    <= '0;
        sawAccess <= 1'b1;
      end else if (idleRise && gapCnt < GAP_W'(MIN_GAP)) begin
        gapCnt <= gapCnt + 1'b1;
      end
      if (csFall && sawAccess && gapCnt < GAP_W'(MIN_GAP)) gapErr <= 1'b1;
    end
  end

  always_comb begin
    strobes.shiftIn     = sclkFall;
    strobes.shiftOut    = sclkRise & readActive;
    strobes.loadTx      = csFall;
    strobes.commitWrite = csRise & (bitCnt == CNT_W'(8)) & ~readActive;
    strobes.endRead     = csRise & readActive;
    sdoOe               = readActive & ~csN;
  end

  p_bitcnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(9));
  p_gap_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    gapErr |=> gapErr);
  p_read_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readActive) |-> $past(rdPending));
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.shiftIn, strobes.loadTx, strobes.commitWrite, strobes.endRead}));
endmodule

// File: rtl/isp_datapath.sv
module isp_datapath
  import isp_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  ispStrobes_t                strobes,
  input  logic                       sdi,
  input  logic [NUM_CH*STAT_W-1:0]   statusIn,
  input  logic [IO_W-1:0]            ch0Io,
  output logic                       sdo,
  output logic                       rdPending,
  output logic [REG_W-1:0]           cfgReg,
  output logic [NUM_SLOT*REG_W-1:0]  slotRegs,
  output logic [NUM_CH*REG_W-1:0]    sigCtrl
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [REG_W-1:0] rxShift, txShift, statusWord;
  logic [CH_W-1:0]  chSel;
  logic             toCfg, toSlot, toSig;
  logic [NUM_SLOT-1:0] slotWe;
  logic [NUM_CH-1:0]   sigWe;

  assign chSel = cfgReg[3:2];

  always_comb begin
    statusWord = {statusIn[chSel*STAT_W +: STAT_W], ch0Io};
    toCfg  = strobes.commitWrite & rxShift[REG_W-1];
    toSlot = strobes.commitWrite & ~rxShift[REG_W-1] & ~cfgReg[6];
    toSig  = strobes.commitWrite & ~rxShift[REG_W-1] & (cfgReg[6:4] == 3'b101);
    for (int k = 0; k < NUM_SLOT; k++) begin
      slotWe[k] = toSlot && (k / NUM_CH == (cfgReg[1:0] == 2'b10 ? 1 : 0))
                  && (cfgReg[1:0] == 2'b01 || cfgReg[1:0] == 2'b10)
                  && (k % NUM_CH == int'(chSel));
    end
    for (int c = 0; c < NUM_CH; c++) sigWe[c] = toSig && (c == int'(chSel));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      sdo       <= 1'b0;
      cfgReg    <= '0;
      rdPending <= 1'b0;
    end else begin
      if (strobes.shiftIn) rxShift <= {rxShift[REG_W-2:0], sdi};
      if (strobes.loadTx) begin
        txShift <= statusWord;
        sdo     <= 1'b0;
      end else if (strobes.shiftOut) begin
        sdo     <= txShift[REG_W-1];
        txShift <= {txShift[REG_W-2:0], 1'b0};
      end
      if (toCfg) begin
        cfgReg    <= rxShift;
        rdPending <= (rxShift[6:4] == 3'b101);
      end else if (strobes.endRead) begin
        rdPending <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) slotRegs[k*REG_W +: REG_W] <= '0;
      else if (slotWe[k]) slotRegs[k*REG_W +: REG_W] <= rxShift;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sig
    always_ff @(posedge clk) begin
      if (!rstN) sigCtrl[c*REG_W +: REG_W] <= '0;
      else if (sigWe[c]) sigCtrl[c*REG_W +: REG_W] <= rxShift;
    end
  end

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commitWrite |=> $stable(cfgReg));
  p_sig_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commitWrite |=> $stable(sigCtrl));
  p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commitWrite |=> $stable(slotRegs));
  p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.endRead |=> !rdPending);
endmodule

// File: rtl/ind_serial_port.sv
module ind_serial_port
  import isp_pkg::*;
#(
  parameter int MIN_GAP = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csN,
  input  logic                      sclk,
  input  logic                      sdi,
  input  logic [NUM_CH*STAT_W-1:0]  statusIn,
  input  logic [IO_W-1:0]           ch0Io,
  output logic                      sdo,
  output logic                      sdoOe,
  output logic [REG_W-1:0]          cfgReg,
  output logic [NUM_SLOT*REG_W-1:0] slotRegs,
  output logic [NUM_CH*REG_W-1:0]   sigCtrl,
  output logic                      gapErr
);
  ispStrobes_t strobes;
  logic        rdPending;

  isp_ctrl #(.MIN_GAP(MIN_GAP)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .rdPending(rdPending),
    .strobes(strobes), .sdoOe(sdoOe), .gapErr(gapErr)
  );

  isp_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdi(sdi),
    .statusIn(statusIn), .ch0Io(ch0Io), .sdo(sdo), .rdPending(rdPending),
    .cfgReg(cfgReg), .slotRegs(slotRegs), .sigCtrl(sigCtrl)
  );
endmodule

// File: tb/ind_serial_port_tb_top.sv
module ind_serial_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [19:0] statusIn = '0;
  logic [2:0]  ch0Io = '0;
  logic sdo, sdoOe, gapErr;
  logic [7:0]  cfgReg;
  logic [63:0] slotRegs;
  logic [31:0] sigCtrl;
  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  ind_serial_port dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .statusIn(statusIn), .ch0Io(ch0Io), .sdo(sdo), .sdoOe(sdoOe),
    .cfgReg(cfgReg), .slotRegs(slotRegs), .sigCtrl(sigCtrl), .gapErr(gapErr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idleGap(input int rises);
    for (int i = 0; i < rises; i++) begin
      sclk = 1'b0; waitClk(2);
      sclk = 1'b1; waitClk(2);
    end
  endtask

  task automatic xfer(input logic [7:0] data, input int nBits,
                      output logic [7:0] rd, output logic allOe, output logic anyOe);
    rd = '0; allOe = 1'b1; anyOe = 1'b0;
    csN = 1'b0; waitClk(4);
    for (int i = 0; i < nBits; i++) begin
      sdi = (i < 8) ? data[7-i] : 1'b0;
      sclk = 1'b0; waitClk(4);
      sclk = 1'b1; waitClk(4);
      if (i < 8) rd[7-i] = sdo;
      allOe &= sdoOe;
      anyOe |= sdoOe;
    end
    csN = 1'b1; waitClk(4);
  endtask

  task automatic access(input logic [7:0] data, input int nBits, input int gap,
                        output logic [7:0] rd, output logic allOe, output logic anyOe);
    idleGap(gap);
    xfer(data, nBits, rd, allOe, anyOe);
  endtask

  task automatic wr(input logic [7:0] data);
    logic [7:0] rd; logic a, b;
    access(data, 8, 3, rd, a, b);
    chk("R9 write leaves sdoOe low", {63'd0, b}, 64'd0);
  endtask

  task automatic testReset();
    chk("R1 cfg", {56'd0, cfgReg}, 64'd0);
    chk("R1 slots", slotRegs, 64'd0);
    chk("R1 sig", {32'd0, sigCtrl}, 64'd0);
    chk("R1 gapErr", {63'd0, gapErr}, 64'd0);
    chk("R1 sdoOe", {63'd0, sdoOe}, 64'd0);
  endtask

  task automatic testSlots();
    wr(8'h85);
    chk("R2 cfg load", {56'd0, cfgReg}, 64'h85);
    wr(8'h2A);
    chk("R3 tx slot ch1", slotRegs, 64'h0000_0000_0000_2A00);
    wr(8'h8A);
    wr(8'h55);
    chk("R3 rx slot ch2", slotRegs, 64'h0055_0000_0000_2A00);
    wr(8'h80);
    wr(8'h11);
    chk("R3 bank 00 dropped", slotRegs, 64'h0055_0000_0000_2A00);
  endtask

  task automatic testLength();
    logic [7:0] rd; logic a, b;
    access(8'hFF, 5, 3, rd, a, b);
    chk("R8 short transfer", {56'd0, cfgReg}, 64'h80);
    access(8'hFF, 9, 3, rd, a, b);
    chk("R8 long transfer", {56'd0, cfgReg}, 64'h80);
  endtask

  task automatic testRead();
    logic [7:0] rd; logic a, b;
    statusIn[14:10] = 5'b10110;
    statusIn[19:15] = 5'b01001;
    ch0Io = 3'b101;
    wr(8'hD8);
    access(8'h00, 8, 3, rd, a, b);
    chk("R6 R7 read ch2", {56'd0, rd}, 64'hB5);
    chk("R9 sdoOe during read", {63'd0, a}, 64'd1);
    chk("R6 read keeps cfg", {56'd0, cfgReg}, 64'hD8);
    chk("R6 read keeps sig", {32'd0, sigCtrl}, 64'd0);
    chk("R9 sdoOe idle", {63'd0, sdoOe}, 64'd0);
    wr(8'h3C);
    chk("R4 sig ch2", {32'd0, sigCtrl}, 64'h003C_0000);
    ch0Io = 3'b010;
    wr(8'hDC);
    access(8'h00, 8, 3, rd, a, b);
    chk("R7 read ch3", {56'd0, rd}, 64'h4A);
  endtask

  task automatic testIgnored();
    wr(8'hC0);
    wr(8'h77);
    chk("R5 slots unchanged", slotRegs, 64'h0055_0000_0000_2A00);
    chk("R5 sig unchanged", {32'd0, sigCtrl}, 64'h003C_0000);
  endtask

  task automatic testGap();
    logic [7:0] rd; logic a, b;
    chk("R10 no error with 3-edge gaps", {63'd0, gapErr}, 64'd0);
    access(8'hC0, 8, 2, rd, a, b);
    chk("R10 short gap flagged", {63'd0, gapErr}, 64'd1);
    access(8'hC0, 8, 4, rd, a, b);
    chk("R10 flag sticky", {63'd0, gapErr}, 64'd1);
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    testReset();
    testSlots();
    testLength();
    testRead();
    testIgnored();
    testGap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule